// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store RISC Core

This block is a small 32-bit processor that completes one instruction in every clock cycle. Each cycle it puts the program counter on the instruction address port and takes the 32-bit instruction word back in the same cycle. It decodes that word and reads up to two operands from a 32-entry register file. It then computes an arithmetic, logic or compare result, a memory address or the next program counter, and commits at most one register write on the rising clock edge.

Data memory is reached through a plain word port meant for an external load/store unit. The address, the write data, a write strobe and a read strobe come out combinationally. A load expects its word on the read-data input within the same cycle. Neither memory port has back-pressure: both memories must answer within the cycle, and the core never stalls. Encodings outside the supported subset execute as no-operations, so a stray word cannot corrupt state.

Top module: `core_top`

## Requirements
- R1: A synchronous reset, sampled high on a rising edge, loads the program counter (imem_addr) with RESET_PC (default 0). This value is visible in the first cycle after reset is released.
- R2: An instruction that is not a branch, jump or register jump advances imem_addr by 4 at the next edge. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0], immediate [15:0], jump field [25:0].
- R3: Register 0 always reads as zero. Any write aimed at it is discarded.
- R4: With opcode 0x00 and shamt 0, funct selects the operation written to rd from rs and rt: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than (result 1 or 0).
- R5: Immediate forms write rt. addi (0x08) and slti (0x0A) sign-extend the immediate. andi (0x0C) and ori (0x0D) zero-extend it.
- R6: lui (0x0F) writes the immediate into bits 31:16 of rt and clears bits 15:0.
- R7: beq (0x04) when rs equals rt, and bne (0x05) when they differ, set the PC to PC+4 plus the sign-extended immediate times 4. Otherwise the PC becomes PC+4.
- R8: j (0x02) and jal (0x03) set the PC to the upper 4 bits of PC+4, then the 26-bit field, then two zero bits. jal also writes PC+4 into register 31.
- R9: jr (opcode 0x00, funct 0x08) sets the PC to the value of rs.
- R10: lw (0x23) drives dmem_addr = rs + sign-extended immediate and raises dmem_re. It writes the dmem_rdata word of the same cycle into rt.
- R11: sw (0x2B) drives dmem_addr = rs + sign-extended immediate, dmem_wdata = rt and raises dmem_we. dmem_we and dmem_re are never high together.
- R12: Every other encoding, including an R-type word with a nonzero shamt or an unlisted funct, writes no register, raises neither memory strobe, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Program counter, the instruction fetch address |
| imem_data | input | 32 | Instruction word for imem_addr, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data, valid in the same cycle |

## Verification
The assertions assume that both memories answer within the cycle and that every register-jump target is word aligned. The alignment check on imem_addr relies on the second of these. The stimulus drives each instruction word and load word shortly after the falling edge and holds it through the next rising edge. Every jr target it loads into a register is a multiple of 4. The bench reads register contents only through stores, after writing those registers first, so unreset storage is never observed.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;
  localparam int OP_W   = 6;
  localparam int SH_W   = 5;
  localparam int LINK_REG = NREG - 1;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_J     = 6'h02;
  localparam logic [OP_W-1:0] OP_JAL   = 6'h03;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_BNE   = 6'h05;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OP_SLTI  = 6'h0A;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'h0C;
  localparam logic [OP_W-1:0] OP_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OP_LUI   = 6'h0F;
  localparam logic [OP_W-1:0] OP_LW    = 6'h23;
  localparam logic [OP_W-1:0] OP_SW    = 6'h2B;

  localparam logic [OP_W-1:0] FN_JR  = 6'h08;
  localparam logic [OP_W-1:0] FN_ADD = 6'h20;
  localparam logic [OP_W-1:0] FN_SUB = 6'h22;
  localparam logic [OP_W-1:0] FN_AND = 6'h24;
  localparam logic [OP_W-1:0] FN_OR  = 6'h25;
  localparam logic [OP_W-1:0] FN_XOR = 6'h26;
  localparam logic [OP_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_LUI
  } alu_op_e;

  typedef enum logic [1:0] {DST_NONE, DST_RD, DST_RT, DST_LINK} dst_e;

  typedef enum logic [2:0] {NPC_SEQ, NPC_BEQ, NPC_BNE, NPC_JUMP, NPC_REG} npc_e;

  typedef struct packed {
    dst_e    dst;
    alu_op_e alu;
    logic    imm_b;
    logic    imm_zext;
    logic    mem_rd;
    logic    mem_wr;
    npc_e    npc;
  } ctrl_t;
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [SH_W-1:0] shamt,
  input  logic [OP_W-1:0] funct,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '{DST_NONE, ALU_ADD, 1'b0, 1'b0, 1'b0, 1'b0, NPC_SEQ};
    case (op)
      OP_RTYPE: begin
        if (shamt == '0) begin
          case (funct)
            FN_ADD: begin ctrl.dst = DST_RD; ctrl.alu = ALU_ADD; end
            FN_SUB: begin ctrl.dst = DST_RD; ctrl.alu = ALU_SUB; end
            FN_AND: begin ctrl.dst = DST_RD; ctrl.alu = ALU_AND; end
            FN_OR:  begin ctrl.dst = DST_RD; ctrl.alu = ALU_OR;  end
            FN_XOR: begin ctrl.dst = DST_RD; ctrl.alu = ALU_XOR; end
            FN_SLT: begin ctrl.dst = DST_RD; ctrl.alu = ALU_SLT; end
            FN_JR:  ctrl.npc = NPC_REG;
            default: ;
          endcase
        end
      end
      OP_ADDI: begin ctrl.dst = DST_RT; ctrl.imm_b = 1'b1; ctrl.alu = ALU_ADD; end
      OP_SLTI: begin ctrl.dst = DST_RT; ctrl.imm_b = 1'b1; ctrl.alu = ALU_SLT; end
      OP_ANDI: begin
        ctrl.dst = DST_RT; ctrl.imm_b = 1'b1; ctrl.imm_zext = 1'b1; ctrl.alu = ALU_AND;
      end
      OP_ORI: begin
        ctrl.dst = DST_RT; ctrl.imm_b = 1'b1; ctrl.imm_zext = 1'b1; ctrl.alu = ALU_OR;
      end
      OP_LUI: begin ctrl.dst = DST_RT; ctrl.imm_b = 1'b1; ctrl.alu = ALU_LUI; end
      OP_LW: begin
        ctrl.dst = DST_RT; ctrl.imm_b = 1'b1; ctrl.mem_rd = 1'b1; ctrl.alu = ALU_ADD;
      end
      OP_SW:  begin ctrl.imm_b = 1'b1; ctrl.mem_wr = 1'b1; ctrl.alu = ALU_ADD; end
      OP_BEQ: ctrl.npc = NPC_BEQ;
      OP_BNE: ctrl.npc = NPC_BNE;
      OP_J:   ctrl.npc = NPC_JUMP;
      OP_JAL: begin ctrl.npc = NPC_JUMP; ctrl.dst = DST_LINK; end
      default: ;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int W   = 32,
  parameter int N   = 32,
  parameter int NRD = 2
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [$clog2(N)-1:0]           waddr,
  input  logic [W-1:0]                   wdata,
  input  logic [NRD-1:0][$clog2(N)-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]          rdata
);
  localparam int AW = $clog2(N);

  logic [W-1:0] regs [1:N-1];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == AW'(0)) ? '0 : regs[raddr[p]];
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_LUI: y = {b[IW-1:0], {(W-IW){1'b0}}};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/core_top.sv
module core_top
  import core_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int HI_W = XLEN - TGT_W - 2;

  logic [OP_W-1:0]   op, funct;
  logic [SH_W-1:0]   shamt;
  logic [RIDX_W-1:0] rs, rt, rd, waddr;
  logic [IMM_W-1:0]  imm;
  logic [TGT_W-1:0]  tgt;
  ctrl_t             ctrl;

  logic [XLEN-1:0] pc, pc4, pc_next;
  logic [XLEN-1:0] imm_sext, imm_ext, src_b, alu_y, wdata;
  logic [XLEN-1:0] rs_val, rt_val;
  logic [1:0][XLEN-1:0] rd_pair;

  assign op    = imem_data[31:26];
  assign rs    = imem_data[25:21];
  assign rt    = imem_data[20:16];
  assign rd    = imem_data[15:11];
  assign shamt = imem_data[10:6];
  assign funct = imem_data[5:0];
  assign imm   = imem_data[IMM_W-1:0];
  assign tgt   = imem_data[TGT_W-1:0];

  core_decode u_decode (.op(op), .shamt(shamt), .funct(funct), .ctrl(ctrl));

  core_regfile #(.W(XLEN), .N(NREG), .NRD(2)) u_regfile (
    .clk  (clk),
    .we   (ctrl.dst != DST_NONE),
    .waddr(waddr),
    .wdata(wdata),
    .raddr({rt, rs}),
    .rdata(rd_pair)
  );
  assign rs_val = rd_pair[0];
  assign rt_val = rd_pair[1];

  assign imm_sext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_ext  = ctrl.imm_zext ? {{(XLEN-IMM_W){1'b0}}, imm} : imm_sext;
  assign src_b    = ctrl.imm_b ? imm_ext : rt_val;

  core_alu #(.W(XLEN), .IW(IMM_W)) u_alu (.a(rs_val), .b(src_b), .op(ctrl.alu), .y(alu_y));

  always_comb begin
    case (ctrl.dst)
      DST_RD:   waddr = rd;
      DST_LINK: waddr = RIDX_W'(LINK_REG);
      default:  waddr = rt;
    endcase
  end

  assign wdata = (ctrl.dst == DST_LINK) ? pc4 :
                 ctrl.mem_rd            ? dmem_rdata : alu_y;

  assign pc4 = pc + XLEN'(4);

  always_comb begin
    case (ctrl.npc)
      NPC_BEQ:  pc_next = (rs_val == rt_val) ? pc4 + (imm_sext << 2) : pc4;
      NPC_BNE:  pc_next = (rs_val != rt_val) ? pc4 + (imm_sext << 2) : pc4;
      NPC_JUMP: pc_next = {pc4[XLEN-1 -: HI_W], tgt, 2'b00};
      NPC_REG:  pc_next = rs_val;
      default:  pc_next = pc4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= pc_next;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_wr;
  assign dmem_re    = ctrl.mem_rd;
endmodule

// File: rtl/core_checker.sv
module core_checker
  import core_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imem_addr,
  input logic [XLEN-1:0] imem_data,
  input logic [XLEN-1:0] dmem_wdata,
  input logic            dmem_we,
  input logic            dmem_re
);
  logic [OP_W-1:0]   c_op;
  logic [RIDX_W-1:0] c_rt;
  logic              c_plain, c_jump;
  logic [3:0]        c_hi;
  logic [XLEN-1:0]   c_jtgt;

  assign c_op    = imem_data[31:26];
  assign c_rt    = imem_data[20:16];
  assign c_plain = c_op inside {OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_LUI, OP_LW, OP_SW};
  assign c_jump  = (c_op == OP_J) || (c_op == OP_JAL);
  assign c_hi    = 4'((imem_addr + 32'd4) >> 28);
  assign c_jtgt  = {c_hi, imem_data[25:0], 2'b00};

  p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> imem_addr == RESET_PC);

  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(c_plain)) |-> imem_addr == $past(imem_addr) + 32'd4);

  p_aligned_pc_r2: assert property (@(posedge clk) disable iff (rst)
    imem_addr[1:0] == 2'b00);

  p_zero_store_r3: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_SW && c_rt == '0) |-> dmem_wdata == '0);

  p_jump_target_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(c_jump)) |-> imem_addr == $past(c_jtgt));

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));

  p_we_only_sw_r12: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> c_op == OP_SW);

  p_re_only_lw_r12: assert property (@(posedge clk) disable iff (rst)
    dmem_re |-> c_op == OP_LW);
endmodule

bind core_top core_checker #(.RESET_PC(RESET_PC)) u_core_checker (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_re(dmem_re)
);

// File: tb/test_core_top.sv
`timescale 1ns/1ps
module test_core_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_pc = 32'd0;
  logic [31:0] rdata_drv = 32'd0;

  always #5 clk = ~clk;

  core_top i_core_top (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
  );

  function automatic logic [31:0] rtype(logic [5:0] fn, logic [4:0] s, logic [4:0] t, logic [4:0] d);
    return {6'h00, s, t, d, 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] o, logic [4:0] s, logic [4:0] t, logic [15:0] i);
    return {o, s, t, i};
  endfunction
  function automatic logic [31:0] jtype(logic [5:0] o, logic [25:0] t);
    return {o, t};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input string tag);
    @(negedge clk);
    imem_data  = ins;
    dmem_rdata = rdata_drv;
    #1;
    chk(imem_addr == exp_pc, tag, imem_addr, exp_pc);
    exp_pc = exp_pc + 32'd4;
  endtask

  task automatic observe(input logic [4:0] r, input logic [31:0] exp, input string tag);
    issue(itype(6'h2B, 5'd0, r, 16'h0000), tag);
    chk(dmem_we === 1'b1 && dmem_wdata == exp, tag, dmem_wdata, exp);
  endtask

  task automatic load_const(input logic [4:0] r, input logic [31:0] v);
    issue(itype(6'h0F, 5'd0, r, v[31:16]), "R2");
    issue(itype(6'h0D, r, r, v[15:0]), "R2");
  endtask

  function automatic logic [31:0] r_ref(int k, logic [31:0] a, logic [31:0] b);
    case (k)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] i_ref(int k, logic [31:0] a, logic [15:0] i);
    logic [31:0] s = {{16{i[15]}}, i};
    logic [31:0] z = {16'h0000, i};
    case (k)
      0: return a + s;
      1: return ($signed(a) < $signed(s)) ? 32'd1 : 32'd0;
      2: return a & z;
      default: return a | z;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [6];
    logic [15:0] imms [6];
    logic [5:0]  fns  [6];
    logic [5:0]  iops [4];
    logic [31:0] p;
    vals = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678};
    imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h00F0};
    fns  = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A};
    iops = '{6'h08, 6'h0A, 6'h0C, 6'h0D};
    imem_data  = 32'd0;
    dmem_rdata = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(imem_addr == 32'd0, "R1 reset pc", imem_addr, 32'd0);
    exp_pc = 32'd4;

    // R3: writes to register 0 are discarded
    issue(itype(6'h08, 5'd0, 5'd0, 16'h0055), "R2");
    observe(5'd0, 32'd0, "R3 addi to r0");
    load_const(5'd1, 32'hCAFE_F00D);
    issue(rtype(6'h20, 5'd1, 5'd1, 5'd0), "R2");
    observe(5'd0, 32'd0, "R3 add to r0");

    // R4: register-register sweep
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        load_const(5'd1, vals[i]);
        load_const(5'd2, vals[j]);
        for (int k = 0; k < 6; k++) begin
          issue(rtype(fns[k], 5'd1, 5'd2, 5'd3), "R2");
          observe(5'd3, r_ref(k, vals[i], vals[j]), "R4 alu");
        end
      end
    end

    // R5 and R6: immediate sweep
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        load_const(5'd1, vals[i]);
        for (int k = 0; k < 4; k++) begin
          issue(itype(iops[k], 5'd1, 5'd4, imms[j]), "R2");
          observe(5'd4, i_ref(k, vals[i], imms[j]), "R5 imm");
        end
      end
      issue(itype(6'h0F, 5'd0, 5'd5, imms[i]), "R2");
      observe(5'd5, {imms[i], 16'h0000}, "R6 lui");
    end

    // R7: branches
    load_const(5'd1, 32'd7);
    load_const(5'd2, 32'd7);
    load_const(5'd3, 32'd8);
    p = exp_pc;
    issue(itype(6'h04, 5'd1, 5'd2, 16'h0003), "R2");
    exp_pc = p + 32'd4 + 32'd12;
    issue(32'd0, "R7 beq taken forward");
    p = exp_pc;
    issue(itype(6'h04, 5'd1, 5'd3, 16'h0003), "R2");
    issue(32'd0, "R7 beq not taken");
    p = exp_pc;
    issue(itype(6'h05, 5'd1, 5'd3, 16'hFFFE), "R2");
    exp_pc = p + 32'd4 - 32'd8;
    issue(32'd0, "R7 bne taken backward");
    issue(itype(6'h05, 5'd1, 5'd2, 16'h0010), "R2");
    issue(32'd0, "R7 bne not taken");

    // R9: register jump into a high region
    load_const(5'd6, 32'hA000_0000);
    issue(rtype(6'h08, 5'd6, 5'd0, 5'd0), "R2");
    exp_pc = 32'hA000_0000;
    issue(32'd0, "R9 jr");

    // R8: jumps keep the upper PC bits; jal links
    issue(jtype(6'h02, 26'h000_0040), "R2");
    exp_pc = 32'hA000_0100;
    issue(32'd0, "R8 j");
    p = exp_pc;
    issue(jtype(6'h03, 26'h000_0080), "R2");
    exp_pc = 32'hA000_0200;
    observe(5'd31, p + 32'd4, "R8 jal link");

    // R10: load
    load_const(5'd7, 32'h0000_0100);
    rdata_drv = 32'hDEAD_BEEF;
    issue(itype(6'h23, 5'd7, 5'd8, 16'hFFFC), "R2");
    chk(dmem_re === 1'b1 && dmem_we === 1'b0 && dmem_addr == 32'h0000_00FC,
        "R10 lw addr", dmem_addr, 32'h0000_00FC);
    rdata_drv = 32'd0;
    observe(5'd8, 32'hDEAD_BEEF, "R10 lw data");

    // R11: store address and data
    issue(itype(6'h2B, 5'd7, 5'd8, 16'h0010), "R2");
    chk(dmem_we === 1'b1 && dmem_re === 1'b0 && dmem_addr == 32'h0000_0110,
        "R11 sw addr", dmem_addr, 32'h0000_0110);
    chk(dmem_wdata == 32'hDEAD_BEEF, "R11 sw data", dmem_wdata, 32'hDEAD_BEEF);

    // R12: unsupported encodings are no-ops
    load_const(5'd9, 32'h0000_55AA);
    issue(itype(6'h3F, 5'd0, 5'd9, 16'h1234), "R12 pc");
    chk(dmem_we === 1'b0 && dmem_re === 1'b0, "R12 strobes", {30'd0, dmem_we, dmem_re}, 32'd0);
    issue(rtype(6'h3F, 5'd0, 5'd0, 5'd9), "R12 pc");
    issue({6'h00, 5'd1, 5'd1, 5'd9, 5'd3, 6'h20}, "R12 pc");
    observe(5'd9, 32'h0000_55AA, "R12 register kept");

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    imem_data = 32'd0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(imem_addr == 32'd0, "R1 mid-run reset", imem_addr, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule